// File: doc/BRIEF.md
# Camera Frame Buffer Controller

This block sits between an 8-bit camera pixel stream and an external asynchronous SRAM that is sized for one frame. Every strobed camera pixel goes straight to a downstream consumer one clock later, whether or not anything is being stored. While the save control is high, the block copies captured frames into the SRAM. It has two save modes. In the first, it stores one complete frame and then leaves it untouched. In the second, it rewrites the buffer on every other frame it sees.

A read enable replays the stored frame, starting at address zero, on a separate pixel output with its own strobe and its own start-of-frame marker. Writes always win the single SRAM port: a read waits for any cycle that carries a write, so the replayed stream slows down but loses no pixel. An empty flag stays high until the first complete frame has been written.

Top module: `fbuf_sram_ctrl`

## Requirements
- R1: Each camera pixel with `pix_stb` high appears on `cam_pix` with `cam_stb` high one clock later. `cam_sof` is high on that same cycle exactly when `pix_sof` marked the pixel.
- R2: While `save_en` is low, `sram_we_n` stays high.
- R3: Storing starts only on a strobed pixel that carries `pix_sof`. That pixel goes to address 0, and each following strobed pixel goes to the next address, one clock after it was accepted. If `save_en` rises in the middle of a frame, the rest of that frame is not written.
- R4: When `save_once` is 1 (store-once mode), the first complete frame is written and later frames are not. Taking `save_en` low re-arms the mode.
- R5: When `save_once` is 0 (every-second mode), frames are counted from the time `save_en` went high. The first, third, fifth and later odd frames are written; the even-numbered frames are not.
- R6: `buf_empty` is 1 after reset. It goes to 0 at the clock edge that ends the write to address FRAME_PIX-1, and it stays 0 until reset.
- R7: While `rd_en` is high and `buf_empty` is 0, the block replays addresses 0 to FRAME_PIX-1 in order on `mem_pix`, each with a `mem_stb` pulse. `mem_sof` is high with the pixel from address 0. A pass that has started always runs to the end.
- R8: A write and a read never share a cycle, and a pending write takes the port first. A read that is held off keeps its address, so the replayed stream neither skips nor repeats a pixel.
- R9: `sram_we_n` and `sram_oe_n` are never low in the same cycle. `sram_cs_n` is low exactly when one of them is low. The block drives `sram_dq` only in write cycles, and it drives the pixel being written.
- R10: During synchronous active-low reset, `sram_we_n`, `sram_oe_n` and `sram_cs_n` are 1, all strobes are 0, and `buf_empty` is 1.
- R11: While `buf_empty` is 1, `rd_en` has no effect: `sram_oe_n` stays high and no `mem_stb` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_in | input | PIX_W | Camera pixel |
| pix_stb | input | 1 | Pixel valid strobe |
| pix_sof | input | 1 | Marks the first pixel of a frame |
| save_en | input | 1 | Enables frame storing |
| save_once | input | 1 | 1 = store once, 0 = every second frame |
| rd_en | input | 1 | Requests replay of the stored frame |
| cam_pix | output | PIX_W | Forwarded camera pixel |
| cam_stb | output | 1 | Strobe for forwarded pixel |
| cam_sof | output | 1 | First-pixel marker for forwarded stream |
| mem_pix | output | PIX_W | Replayed pixel from SRAM |
| mem_stb | output | 1 | Strobe for replayed pixel |
| mem_sof | output | 1 | First-pixel marker for replayed stream |
| buf_empty | output | 1 | High while no complete frame is stored |
| sram_addr | output | ADDR_W | SRAM address |
| sram_cs_n | output | 1 | SRAM chip select, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_dq | inout | PIX_W | SRAM data bus |

## Verification
The stimulus covers three kinds of frame sequence, each aimed at a different fault:

- **Frames with save off, and a frame whose save starts partway through.** These show that writes happen only from a frame boundary, and only when storing is enabled.
- **Store-once and every-second sequences, each frame with a distinct pixel pattern.** Which pattern ends up in memory shows which frames were written. It also catches a mode that re-arms or counts frame parity wrongly.
- **Replay during back-to-back camera pixels that force writes every cycle.** This tests the port priority: a stalled read that skipped or repeated an address would break the expected order of the replayed stream.

// File: rtl/fbuf_pkg.sv
// Shared definitions for the camera frame buffer controller.
package fbuf_pkg;
    // Frame save policy selected by the save_once input.
    typedef enum logic {
        SAVE_EVERY2 = 1'b0,
        SAVE_ONCE   = 1'b1
    } save_mode_e;
endpackage

// File: rtl/fbuf_capture.sv
// Camera side: forwards pixels and decides which ones go to SRAM.
// Assumes pixels arrive at most one per clock. Each accepted pixel makes a
// one-cycle write request on the next clock; the port always grants it.
module fbuf_capture
    import fbuf_pkg::*;
#(
    parameter int PIX_W     = 8,
    parameter int ADDR_W    = 8,
    parameter int FRAME_PIX = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIX_W-1:0]  pix_i,
    input  logic              pix_stb_i,
    input  logic              sof_i,
    input  logic              save_i,
    input  logic              once_i,
    output logic [PIX_W-1:0]  cam_pix_o,
    output logic              cam_stb_o,
    output logic              cam_sof_o,
    output logic              wr_req_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [PIX_W-1:0]  wr_data_o,
    output logic              empty_o
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(FRAME_PIX - 1);

    save_mode_e        mode;
    logic              cap_on;
    logic              kept;
    logic              skip_next;
    logic [ADDR_W-1:0] waddr;
    logic              take_frame;

    assign mode = save_mode_e'(once_i);

    // Decide whether the frame starting now gets stored.
    always_comb begin
        if (mode == SAVE_ONCE) take_frame = !kept;
        else                   take_frame = !skip_next;
    end

    // Forward the live camera stream with one register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cam_pix_o <= '0;
            cam_stb_o <= 1'b0;
            cam_sof_o <= 1'b0;
        end else begin
            cam_pix_o <= pix_i;
            cam_stb_o <= pix_stb_i;
            cam_sof_o <= pix_stb_i & sof_i;
        end
    end

    // Track frame selection and issue one write request per stored pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_on    <= 1'b0;
            kept      <= 1'b0;
            skip_next <= 1'b0;
            waddr     <= '0;
            wr_req_o  <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
        end else begin
            wr_req_o <= 1'b0;
            if (!save_i) begin
                cap_on    <= 1'b0;
                kept      <= 1'b0;
                skip_next <= 1'b0;
            end else if (pix_stb_i) begin
                if (sof_i) begin
                    if (mode == SAVE_EVERY2) skip_next <= !skip_next;
                    if (take_frame) begin
                        wr_req_o  <= 1'b1;
                        wr_addr_o <= '0;
                        wr_data_o <= pix_i;
                        waddr     <= ADDR_W'(1);
                        cap_on    <= (LAST != '0);
                        if (LAST == '0 && mode == SAVE_ONCE) kept <= 1'b1;
                    end else begin
                        cap_on <= 1'b0;
                    end
                end else if (cap_on) begin
                    wr_req_o  <= 1'b1;
                    wr_addr_o <= waddr;
                    wr_data_o <= pix_i;
                    waddr     <= waddr + ADDR_W'(1);
                    if (waddr == LAST) begin
                        cap_on <= 1'b0;
                        if (mode == SAVE_ONCE) kept <= 1'b1;
                    end
                end
            end
        end
    end

    // Clear the empty flag once the last address of a frame is written.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  empty_o <= 1'b1;
        else if (wr_req_o && wr_addr_o == LAST)      empty_o <= 1'b0;
    end

    // R6: empty falls only right after the final address was written.
    a_r6_empty_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(empty_o) |-> $past(wr_req_o && wr_addr_o == LAST));
    // R2: no write request follows a cycle with saving disabled.
    a_r2_no_write_unsaved: assert property (@(posedge clk) disable iff (!rst_n)
        !save_i |=> !wr_req_o);
    // R3: a frame start can only begin storing at address zero.
    a_r3_first_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (save_i && pix_stb_i && sof_i) |=> (!wr_req_o || wr_addr_o == '0));
endmodule

// File: rtl/fbuf_readback.sv
// Replays the stored frame from address 0 upwards.
// Assumes the SRAM returns data within the cycle a read is granted.
// A pass that has started always runs to its end.
module fbuf_readback #(
    parameter int PIX_W     = 8,
    parameter int ADDR_W    = 8,
    parameter int FRAME_PIX = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  logic              empty_i,
    input  logic              grant_i,
    input  logic [PIX_W-1:0]  rdata_i,
    output logic              rd_want_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic [PIX_W-1:0]  mem_pix_o,
    output logic              mem_stb_o,
    output logic              mem_sof_o
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(FRAME_PIX - 1);

    // Sequence read addresses and register the returned pixels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_want_o <= 1'b0;
            rd_addr_o <= '0;
            mem_pix_o <= '0;
            mem_stb_o <= 1'b0;
            mem_sof_o <= 1'b0;
        end else begin
            mem_stb_o <= 1'b0;
            mem_sof_o <= 1'b0;
            if (!rd_want_o) begin
                rd_addr_o <= '0;
                if (rd_en_i && !empty_i) rd_want_o <= 1'b1;
            end else if (grant_i) begin
                mem_pix_o <= rdata_i;
                mem_stb_o <= 1'b1;
                mem_sof_o <= (rd_addr_o == '0);
                if (rd_addr_o == LAST) rd_want_o <= 1'b0;
                else                   rd_addr_o <= rd_addr_o + ADDR_W'(1);
            end
        end
    end

    // R8: a read that was refused holds its address.
    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_want_o && !grant_i) |=> $stable(rd_addr_o));
    // R11: no read is pending while the buffer is empty.
    a_r11_no_read_empty: assert property (@(posedge clk) disable iff (!rst_n)
        empty_i |-> !rd_want_o);
endmodule

// File: rtl/fbuf_sram_port.sv
// Single SRAM port shared by writes and reads; a write always wins.
// Drives the data bus only during a write cycle. Strobes are active low.
module fbuf_sram_port #(
    parameter int PIX_W  = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [PIX_W-1:0]  wr_data_i,
    input  logic              rd_want_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              grant_o,
    output logic [PIX_W-1:0]  rdata_o,
    output logic [ADDR_W-1:0] sram_addr_o,
    output logic              sram_cs_n_o,
    output logic              sram_oe_n_o,
    output logic              sram_we_n_o,
    inout  wire  [PIX_W-1:0]  sram_dq_io
);
    // Arbitrate the port and select the address.
    always_comb begin
        grant_o     = rd_want_i && !wr_req_i;
        sram_we_n_o = !wr_req_i;
        sram_oe_n_o = !grant_o;
        sram_cs_n_o = !(wr_req_i || grant_o);
        sram_addr_o = wr_req_i ? wr_addr_i : rd_addr_i;
    end

    assign sram_dq_io = wr_req_i ? wr_data_i : {PIX_W{1'bz}};
    assign rdata_o    = sram_dq_io;

    // R9: write and read enables never overlap.
    a_r9_we_oe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_we_n_o && !sram_oe_n_o));
    // R8: a concurrent read request is refused while a write is pending.
    a_r8_write_first: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && rd_want_i) |-> (sram_oe_n_o && !sram_we_n_o));
endmodule

// File: rtl/fbuf_sram_ctrl.sv
// Camera frame buffer controller top level.
// Forwards live pixels, stores selected frames in an external one-frame SRAM
// and replays the stored frame on request. Requires FRAME_PIX <= 2**ADDR_W.
module fbuf_sram_ctrl #(
    parameter int PIX_W     = 8,
    parameter int ADDR_W    = 8,
    parameter int FRAME_PIX = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIX_W-1:0]  pix_in,
    input  logic              pix_stb,
    input  logic              pix_sof,
    input  logic              save_en,
    input  logic              save_once,
    input  logic              rd_en,
    output logic [PIX_W-1:0]  cam_pix,
    output logic              cam_stb,
    output logic              cam_sof,
    output logic [PIX_W-1:0]  mem_pix,
    output logic              mem_stb,
    output logic              mem_sof,
    output logic              buf_empty,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    inout  wire  [PIX_W-1:0]  sram_dq
);
    logic              wr_req;
    logic [ADDR_W-1:0] wr_addr;
    logic [PIX_W-1:0]  wr_data;
    logic              rd_want;
    logic [ADDR_W-1:0] rd_addr;
    logic              grant;
    logic [PIX_W-1:0]  rdata;

    fbuf_capture #(.PIX_W(PIX_W), .ADDR_W(ADDR_W), .FRAME_PIX(FRAME_PIX)) u_cap (
        .clk(clk), .rst_n(rst_n), .pix_i(pix_in), .pix_stb_i(pix_stb),
        .sof_i(pix_sof), .save_i(save_en), .once_i(save_once),
        .cam_pix_o(cam_pix), .cam_stb_o(cam_stb), .cam_sof_o(cam_sof),
        .wr_req_o(wr_req), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .empty_o(buf_empty)
    );

    fbuf_readback #(.PIX_W(PIX_W), .ADDR_W(ADDR_W), .FRAME_PIX(FRAME_PIX)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en), .empty_i(buf_empty),
        .grant_i(grant), .rdata_i(rdata), .rd_want_o(rd_want),
        .rd_addr_o(rd_addr), .mem_pix_o(mem_pix), .mem_stb_o(mem_stb),
        .mem_sof_o(mem_sof)
    );

    fbuf_sram_port #(.PIX_W(PIX_W), .ADDR_W(ADDR_W)) u_port (
        .clk(clk), .rst_n(rst_n), .wr_req_i(wr_req), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_want_i(rd_want), .rd_addr_i(rd_addr),
        .grant_o(grant), .rdata_o(rdata), .sram_addr_o(sram_addr),
        .sram_cs_n_o(sram_cs_n), .sram_oe_n_o(sram_oe_n),
        .sram_we_n_o(sram_we_n), .sram_dq_io(sram_dq)
    );

    // R7: a replayed pixel never appears while the buffer is empty.
    a_r7_stream_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
        mem_stb |-> !buf_empty);
endmodule

// File: tb/fbuf_sram_ctrl_test.sv
// Self-checking bench with a behavioural reference model and SRAM model.
module fbuf_sram_ctrl_test;
    localparam int N  = 48;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] pix_in = '0;
    logic pix_stb = 1'b0, pix_sof = 1'b0;
    logic save_en = 1'b0, save_once = 1'b1, rd_en = 1'b0;
    logic [7:0] cam_pix, mem_pix;
    logic cam_stb, cam_sof, mem_stb, mem_sof, buf_empty;
    logic [AW-1:0] sram_addr;
    logic sram_cs_n, sram_oe_n, sram_we_n;
    wire  [7:0] sram_dq;

    logic [7:0] sram [0:(1<<AW)-1];
    int writes_seen = 0;

    always #2.5 clk = !clk;

    fbuf_sram_ctrl #(.PIX_W(8), .ADDR_W(AW), .FRAME_PIX(N)) uut (
        .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .pix_stb(pix_stb),
        .pix_sof(pix_sof), .save_en(save_en), .save_once(save_once),
        .rd_en(rd_en), .cam_pix(cam_pix), .cam_stb(cam_stb),
        .cam_sof(cam_sof), .mem_pix(mem_pix), .mem_stb(mem_stb),
        .mem_sof(mem_sof), .buf_empty(buf_empty), .sram_addr(sram_addr),
        .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_dq(sram_dq)
    );

    // Behavioural asynchronous SRAM.
    assign sram_dq = (!sram_cs_n && !sram_oe_n && sram_we_n) ? sram[sram_addr] : 8'hzz;
    always @(posedge clk) begin
        if (!sram_cs_n && !sram_we_n) begin
            sram[sram_addr] <= sram_dq;
            writes_seen <= writes_seen + 1;
        end
    end

    int nchk = 0, nfail = 0, cyc = 0;

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            nfail = nfail + 1;
            $display("FAIL watchdog: got %0d cycles exp fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: got %0h exp %0h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 37 + i * 5 + 3) & 255);
    endfunction

    // Reference model state.
    bit m_on = 0, m_kept = 0, m_par = 0, m_empty = 1;
    int m_idx = 0;
    bit w_v = 0; int w_a = 0; int w_d = 0;
    logic [7:0] e_pix; bit e_stb = 0, e_sof = 0;
    int st_seed = 0, st_idx = 0, st_total = 0;

    task automatic model_edge();
        bit nv = 0; int na = 0;
        if (w_v && w_a == N - 1) m_empty = 0;
        e_pix = pix_in; e_stb = pix_stb; e_sof = pix_stb & pix_sof;
        if (!save_en) begin
            m_on = 0; m_kept = 0; m_par = 0;
        end else if (pix_stb) begin
            if (pix_sof) begin
                bit take = save_once ? !m_kept : !m_par;
                if (!save_once) m_par = !m_par;
                if (take) begin
                    nv = 1; na = 0; m_idx = 1; m_on = (N > 1);
                end else m_on = 0;
            end else if (m_on) begin
                nv = 1; na = m_idx;
                if (m_idx == N - 1) begin
                    m_on = 0;
                    if (save_once) m_kept = 1;
                end
                m_idx++;
            end
        end
        w_v = nv; w_a = na; w_d = pix_in;
    endtask

    task automatic compare();
        chk(cam_stb == e_stb, "R1 cam_stb", cam_stb, e_stb);
        chk(cam_sof == e_sof, "R1 cam_sof", cam_sof, e_sof);
        if (e_stb) chk(cam_pix == e_pix, "R1 cam_pix", cam_pix, e_pix);
        chk(sram_we_n == !w_v, "R3 write timing", sram_we_n, !w_v);
        if (w_v) begin
            chk(sram_addr == AW'(w_a), "R3 write addr", sram_addr, w_a);
            chk(sram_dq == 8'(w_d), "R9 write data", sram_dq, w_d);
        end
        if (!save_en && !w_v) chk(sram_we_n, "R2 no write", sram_we_n, 1);
        chk(buf_empty == m_empty, "R6 empty", buf_empty, m_empty);
        chk(!(!sram_we_n && !sram_oe_n), "R8 no overlap", sram_oe_n, 1);
        chk(sram_cs_n == (sram_we_n & sram_oe_n), "R9 cs", sram_cs_n, sram_we_n & sram_oe_n);
        if (m_empty) chk(!mem_stb && sram_oe_n, "R11 idle when empty", mem_stb, 0);
        if (mem_stb) begin
            chk(mem_pix == pat(st_seed, st_idx), "R7 replay pixel", mem_pix, pat(st_seed, st_idx));
            chk(mem_sof == (st_idx == 0), "R7 replay sof", mem_sof, st_idx == 0);
            st_idx = (st_idx + 1) % N;
            st_total++;
        end
    endtask

    task automatic tick(input logic stb, input logic sof, input logic [7:0] d);
        pix_stb = stb; pix_sof = sof; pix_in = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic send_frame(input int seed, input bit gaps);
        for (int i = 0; i < N; i++) begin
            tick(1'b1, i == 0, pat(seed, i));
            if (gaps && (i % 3 == 1)) tick(1'b0, 1'b0, 8'h00);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 8'h00);
    endtask

    task automatic mem_is(input int seed, input string tag);
        int bad = 0;
        for (int i = 0; i < N; i++) if (sram[i] != pat(seed, i)) bad++;
        chk(bad == 0, tag, bad, 0);
    endtask

    initial begin
        int w0;
        for (int i = 0; i < (1 << AW); i++) sram[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(sram_we_n && sram_oe_n && sram_cs_n, "R10 strobes high", {sram_we_n, sram_oe_n, sram_cs_n}, 7);
        chk(!cam_stb && !mem_stb && buf_empty, "R10 outputs", {cam_stb, mem_stb, buf_empty}, 1);
        rst_n = 1'b1;

        // R2, R11: frames with save off; rd_en ignored while empty.
        rd_en = 1'b1;
        send_frame(5, 1'b1);
        send_frame(6, 1'b0);
        chk(writes_seen == 0, "R2 write count", writes_seen, 0);
        chk(st_total == 0, "R11 no replay", st_total, 0);
        rd_en = 1'b0;

        // R3: save raised mid-frame, remainder skipped.
        save_once = 1'b1;
        for (int i = 0; i < N; i++) begin
            if (i == 10) save_en = 1'b1;
            tick(1'b1, i == 0, pat(7, i));
        end
        chk(writes_seen == 0, "R3 partial frame skipped", writes_seen, 0);

        // R4: store once, then later frames ignored.
        send_frame(1, 1'b1);
        idle(2);
        mem_is(1, "R4 first frame stored");
        chk(!buf_empty, "R6 empty cleared", buf_empty, 0);
        w0 = writes_seen;
        send_frame(2, 1'b0);
        idle(2);
        chk(writes_seen == w0, "R4 later frame ignored", writes_seen, w0);
        mem_is(1, "R4 frame kept");

        // R7: replay without contention.
        st_seed = 1; st_idx = 0; st_total = 0;
        rd_en = 1'b1;
        idle(2 * N + 4);
        rd_en = 1'b0;
        idle(N + 4);
        chk(st_total >= 2 * N && st_idx == 0, "R7 whole passes", st_total, 2 * N);

        // R8: replay while back-to-back writes of identical content.
        save_en = 1'b0; idle(1);
        save_once = 1'b0; save_en = 1'b1;
        st_total = 0;
        rd_en = 1'b1;
        for (int f = 0; f < 4; f++) send_frame(1, 1'b0);
        idle(3);
        rd_en = 1'b0;
        idle(N + 4);
        chk(st_total > 0 && st_idx == 0, "R8 stalled replay complete", st_total, N);

        // R5: every-second mode with distinct patterns.
        save_en = 1'b0; idle(1);
        save_en = 1'b1;
        w0 = writes_seen;
        send_frame(11, 1'b1);
        send_frame(12, 1'b0);
        send_frame(13, 1'b1);
        send_frame(14, 1'b0);
        idle(2);
        chk(writes_seen - w0 == 2 * N, "R5 write count", writes_seen - w0, 2 * N);
        mem_is(13, "R5 third frame stored");

        // R4: re-arm store-once after dropping save.
        save_en = 1'b0; idle(1);
        save_once = 1'b1; save_en = 1'b1;
        send_frame(21, 1'b0);
        send_frame(22, 1'b0);
        idle(2);
        mem_is(21, "R4 re-armed store");

        // R7: final replay of the re-armed frame.
        st_seed = 21; st_idx = 0; st_total = 0;
        rd_en = 1'b1;
        idle(N + 2);
        rd_en = 1'b0;
        idle(N + 4);
        chk(st_total >= N && st_idx == 0, "R7 final pass", st_total, N);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule